// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block is the last digital stage in front of a parallel converter output port. It receives two signed 16-bit sample streams, one per channel, qualified by a shared strobe. It recodes each sample into the number format chosen by configuration, can flip every bit of the result, and registers the words onto two output buses. Each bus has a drive-enable output that the pad ring uses to tristate it. A per-channel out-of-range flag is produced from the sample itself, from a programmable magnitude limit, or from an external analog trip bit.

An interleaved mode carries both channels on the first bus. The channel A word appears first and the channel B word follows one clock later. A data clock output marks the cycle in which each new sample (or A word) appears, and its polarity can be reversed. All configuration inputs are static and are held by surrounding logic.

Top module: `dual_sample_formatter`

## Requirements
- R1: The format select `cfg_code` picks the code. 0 and 3 give offset binary (sample XOR 16'h8000). 1 gives the sample unchanged, which is twos complement. 2 gives Gray code, formed from the offset-binary value v as v XOR (v >> 1); for example, a sample of 0 becomes 16'hC000.
- R2: When `cfg_invert` is 1, every bit of each formatted word is complemented after the format conversion.
- R3: While `cfg_hiz` is 1, both `bus_a_en` and `bus_b_en` are 0. While `cfg_merge` is 1, `bus_b_en` is 0. In all other cases both enables are 1.
- R4: When `in_valid` is high at a rising edge, the formatted words and both flags appear on the outputs after that edge and are held until the next accepted strobe. The raw data clock (`dclk_out` XOR `cfg_clk_inv`) is 1 in exactly the cycle that follows a strobe.
- R5: With `cfg_merge` set, `bus_a` carries the A word in the cycle after a strobe, with the raw data clock at 1. In the following cycle it carries the B word, with the raw data clock at 0, provided no new strobe arrives. A strobe that arrives in that B cycle takes priority, and the earlier B word is never shown. The B word is also always present on `bus_b`.
- R6: `cfg_clk_inv` = 1 complements `dclk_out`.
- R7: Flag mode 0 (`cfg_ovr_mode`) sets a channel's flag when its sample is a saturated code, 16'h7FFF or 16'h8000, and clears it otherwise.
- R8: Flag mode 1 sets the flag when bits [14:9] of the sample magnitude are greater than `cfg_ovr_limit`. The magnitude is the sample itself when the sample is non-negative, and the bitwise complement of the sample when it is negative.
- R9: Flag mode 2 sets the flag when the channel's analog trip input or the mode 0 condition is true. Flag mode 3 holds the flag at 0.
- R10: After reset, both buses read 0, both flags are 0, and the raw data clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_a | input | 16 | Channel A signed sample |
| in_b | input | 16 | Channel B signed sample |
| trip_a | input | 1 | Channel A analog trip |
| trip_b | input | 1 | Channel B analog trip |
| cfg_code | input | 2 | Output number format |
| cfg_invert | input | 1 | Complement output words |
| cfg_hiz | input | 1 | Release both buses |
| cfg_merge | input | 1 | Interleave both channels on bus A |
| cfg_clk_inv | input | 1 | Data clock polarity |
| cfg_ovr_mode | input | 2 | Flag source select |
| cfg_ovr_limit | input | 6 | Magnitude limit for flag mode 1 |
| bus_a | output | 16 | Bus A data |
| bus_b | output | 16 | Bus B data |
| bus_a_en | output | 1 | Bus A drive enable |
| bus_b_en | output | 1 | Bus B drive enable |
| ovr_a | output | 1 | Channel A out-of-range flag |
| ovr_b | output | 1 | Channel B out-of-range flag |
| dclk_out | output | 1 | Data clock |

## Verification
The hardest case to reach from the ports is a strobe that arrives during the B cycle of interleaved mode. In that case the pending B word must be dropped, and the new A word must take its place with the data clock high. The bench reaches this state by issuing two strobes on consecutive clocks while merge is set, and it queues only the words that should appear. The magnitude limit is also tested at both sides of its boundary, using a positive sample and its complement.

// File: rtl/fmt_pkg.sv
// Shared encodings for the sample output formatter.
package fmt_pkg;
    typedef enum logic [1:0] {
        CODE_OFFS     = 2'd0,
        CODE_TWOS     = 2'd1,
        CODE_GRAY     = 2'd2,
        CODE_OFFS_ALT = 2'd3
    } code_sel_e;

    typedef enum logic [1:0] {
        OVR_SAT       = 2'd0,
        OVR_LIMIT     = 2'd1,
        OVR_SAT_OR_AN = 2'd2,
        OVR_OFF       = 2'd3
    } ovr_mode_e;
endpackage

// File: rtl/sample_coder.sv
// Recodes one signed sample into the selected output format and applies
// optional bit inversion. Purely combinational; assumes twos-complement input.
module sample_coder
    import fmt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] smp,
    input  code_sel_e     sel,
    input  logic          invert,
    output logic [DW-1:0] word
);
    localparam logic [DW-1:0] SIGN_FLIP = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] offs;
    logic [DW-1:0] coded;

    // Offset-binary base value and format selection.
    always_comb begin
        offs = smp ^ SIGN_FLIP;
        unique case (sel)
            CODE_TWOS: coded = smp;
            CODE_GRAY: coded = offs ^ (offs >> 1);
            default:   coded = offs;
        endcase
        word = invert ? ~coded : coded;
    end
endmodule

// File: rtl/range_flagger.sv
// Computes one channel's out-of-range condition from the sample, a magnitude
// limit and an analog trip bit. Combinational; the caller registers it.
module range_flagger
    import fmt_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 6
) (
    input  logic [DW-1:0] smp,
    input  ovr_mode_e     mode,
    input  logic [TW-1:0] limit,
    input  logic          trip,
    output logic          flag
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

    logic          sat;
    logic [DW-1:0] mag;
    logic          over_lim;

    // Saturation, symmetric magnitude and flag source selection.
    always_comb begin
        sat      = (smp == POS_MAX) || (smp == NEG_MAX);
        mag      = smp[DW-1] ? ~smp : smp;
        over_lim = mag[DW-2 -: TW] > limit;
        unique case (mode)
            OVR_SAT:       flag = sat;
            OVR_LIMIT:     flag = over_lim;
            OVR_SAT_OR_AN: flag = sat | trip;
            default:       flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/out_sequencer.sv
// Registers formatted words and flags on each strobe, sequences the A then B
// word in interleaved mode and generates the raw data clock.
// Assumes configuration is static while strobes arrive.
module out_sequencer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          merge,
    input  logic [DW-1:0] word_a_d,
    input  logic [DW-1:0] word_b_d,
    input  logic [1:0]    flag_d,
    output logic [DW-1:0] lane_a,
    output logic [DW-1:0] lane_b,
    output logic [1:0]    flag_q,
    output logic          dclk_raw
);
    logic [DW-1:0] word_a_q;
    logic [DW-1:0] word_b_q;
    logic          show_b_q;

    // Capture words and flags on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_a_q <= '0;
            word_b_q <= '0;
            flag_q   <= '0;
        end else if (in_valid) begin
            word_a_q <= word_a_d;
            word_b_q <= word_b_d;
            flag_q   <= flag_d;
        end
    end

    // Data clock high for the A cycle; B cycle follows unless a new strobe wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_raw <= 1'b0;
            show_b_q <= 1'b0;
        end else begin
            dclk_raw <= in_valid;
            show_b_q <= dclk_raw && merge && !in_valid;
        end
    end

    // Bus A carries the B word during the second interleaved cycle.
    always_comb begin
        lane_a = show_b_q ? word_b_q : word_a_q;
        lane_b = word_b_q;
    end
endmodule

// File: rtl/dual_sample_formatter.sv
// Output stage for a two-channel sample stream: format, invert, interleave,
// out-of-range flags, bus enables and data clock. Configuration is static.
module dual_sample_formatter
    import fmt_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic          trip_a,
    input  logic          trip_b,
    input  logic [1:0]    cfg_code,
    input  logic          cfg_invert,
    input  logic          cfg_hiz,
    input  logic          cfg_merge,
    input  logic          cfg_clk_inv,
    input  logic [1:0]    cfg_ovr_mode,
    input  logic [TW-1:0] cfg_ovr_limit,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic          bus_a_en,
    output logic          bus_b_en,
    output logic          ovr_a,
    output logic          ovr_b,
    output logic          dclk_out
);
    localparam int NCH = 2;

    logic [DW-1:0] smp  [NCH];
    logic          trip [NCH];
    logic [DW-1:0] word [NCH];
    logic [NCH-1:0] flag_d;
    logic [NCH-1:0] flag_q;
    logic          dclk_raw;

    // Gather channel inputs into arrays for the per-channel lanes.
    always_comb begin
        smp[0]  = in_a;
        smp[1]  = in_b;
        trip[0] = trip_a;
        trip[1] = trip_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        sample_coder #(.DW(DW)) coder_i (
            .smp    (smp[c]),
            .sel    (code_sel_e'(cfg_code)),
            .invert (cfg_invert),
            .word   (word[c])
        );
        range_flagger #(.DW(DW), .TW(TW)) flag_i (
            .smp   (smp[c]),
            .mode  (ovr_mode_e'(cfg_ovr_mode)),
            .limit (cfg_ovr_limit),
            .trip  (trip[c]),
            .flag  (flag_d[c])
        );
    end

    out_sequencer #(.DW(DW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .merge    (cfg_merge),
        .word_a_d (word[0]),
        .word_b_d (word[1]),
        .flag_d   (flag_d),
        .lane_a   (bus_a),
        .lane_b   (bus_b),
        .flag_q   (flag_q),
        .dclk_raw (dclk_raw)
    );

    // Drive enables, flags and data clock polarity.
    always_comb begin
        bus_a_en = !cfg_hiz;
        bus_b_en = !cfg_hiz && !cfg_merge;
        ovr_a    = flag_q[0];
        ovr_b    = flag_q[1];
        dclk_out = dclk_raw ^ cfg_clk_inv;
    end
endmodule

// File: rtl/fmt_checker.sv
// Port-level properties of the output formatter; attached by bind.
module fmt_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_a,
    input logic          cfg_hiz,
    input logic          cfg_merge,
    input logic          cfg_clk_inv,
    input logic [1:0]    cfg_ovr_mode,
    input logic [DW-1:0] bus_a,
    input logic [DW-1:0] bus_b,
    input logic          bus_a_en,
    input logic          bus_b_en,
    input logic          ovr_a,
    input logic          ovr_b,
    input logic          dclk_out
);
    logic raw;
    assign raw = dclk_out ^ cfg_clk_inv;

    p_strobe_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> raw);
    p_idle_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !raw);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !cfg_merge) |=> $stable(bus_a) && $stable(bus_b));
    p_b_after_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && cfg_merge && !in_valid) |=> (bus_a == bus_b));
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hiz |-> (!bus_a_en && !bus_b_en));
    p_flag_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_ovr_mode == 2'd3) |=> (!ovr_a && !ovr_b));
    p_sat_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_ovr_mode == 2'd0 && in_a == {1'b0, {(DW-1){1'b1}}}) |=> ovr_a);
endmodule

bind dual_sample_formatter fmt_checker #(.DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_a         (in_a),
    .cfg_hiz      (cfg_hiz),
    .cfg_merge    (cfg_merge),
    .cfg_clk_inv  (cfg_clk_inv),
    .cfg_ovr_mode (cfg_ovr_mode),
    .bus_a        (bus_a),
    .bus_b        (bus_b),
    .bus_a_en     (bus_a_en),
    .bus_b_en     (bus_b_en),
    .ovr_a        (ovr_a),
    .ovr_b        (ovr_b),
    .dclk_out     (dclk_out)
);

// File: tb/dual_sample_formatter_tb_top.sv
`timescale 1ns/1ps
module dual_sample_formatter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_a = '0, in_b = '0;
    logic        trip_a = 1'b0, trip_b = 1'b0;
    logic [1:0]  cfg_code = 2'd0;
    logic        cfg_invert = 1'b0, cfg_hiz = 1'b0, cfg_merge = 1'b0, cfg_clk_inv = 1'b0;
    logic [1:0]  cfg_ovr_mode = 2'd0;
    logic [5:0]  cfg_ovr_limit = 6'd0;
    logic [15:0] bus_a, bus_b;
    logic        bus_a_en, bus_b_en, ovr_a, ovr_b, dclk_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] wa;
        logic [15:0] wb;
        logic        fa;
        logic        fb;
        bit          bphase;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dual_sample_formatter dut_i (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic logic [15:0] fmt(logic [15:0] s);
        logic [15:0] ob, c;
        ob = s ^ 16'h8000;
        case (cfg_code)
            2'd1: c = s;
            2'd2: c = ob ^ {1'b0, ob[15:1]};
            default: c = ob;
        endcase
        return cfg_invert ? ~c : c;
    endfunction

    function automatic logic flg(logic [15:0] s, logic t);
        logic sat;
        logic [15:0] m;
        sat = (s == 16'h7FFF) || (s == 16'h8000);
        m = s[15] ? ~s : s;
        case (cfg_ovr_mode)
            2'd0: return sat;
            2'd1: return m[14:9] > cfg_ovr_limit;
            2'd2: return sat | t;
            default: return 1'b0;
        endcase
    endfunction

    function automatic item_t mk(logic [15:0] a, logic [15:0] b, logic ta, logic tb, bit bp, string tag);
        item_t it;
        it.wa = bp ? fmt(b) : fmt(a);
        it.wb = fmt(b);
        it.fa = flg(a, ta);
        it.fb = flg(b, tb);
        it.bphase = bp;
        it.tag = tag;
        return it;
    endfunction

    // Driver: queue expectations, pulse the strobe, leave gap cycles.
    task automatic send(logic [15:0] a, logic [15:0] b, logic ta, logic tb, string tag);
        sb_q.push_back(mk(a, b, ta, tb, 1'b0, tag));
        if (cfg_merge) sb_q.push_back(mk(a, b, ta, tb, 1'b1, tag));
        @(negedge clk);
        in_a = a; in_b = b; trip_a = ta; trip_b = tb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare at the falling edge whenever a word is due.
    bit expect_b = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            item_t it;
            if (dclk_out ^ cfg_clk_inv) begin
                if (sb_q.size() == 0) check("R4 unexpected word", 32'd1, 32'd0);
                else begin
                    it = sb_q.pop_front();
                    check({it.tag, " bus_a"}, {16'd0, bus_a}, {16'd0, it.wa});
                    check({it.tag, " bus_b"}, {16'd0, bus_b}, {16'd0, it.wb});
                    check({it.tag, " flags"}, {30'd0, ovr_a, ovr_b}, {30'd0, it.fa, it.fb});
                    expect_b = cfg_merge;
                end
            end else if (expect_b) begin
                expect_b = 1'b0;
                if (sb_q.size() == 0 || !sb_q[0].bphase) check("R5 missing B word", 32'd1, 32'd0);
                else begin
                    it = sb_q.pop_front();
                    check({it.tag, " B word on bus_a"}, {16'd0, bus_a}, {16'd0, it.wa});
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 40000; i++) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state while still in reset and just after release
        check("R10 bus_a", {16'd0, bus_a}, 32'd0);
        check("R10 flags", {30'd0, ovr_a, ovr_b}, 32'd0);
        check("R10 dclk", {31'd0, dclk_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 enables on", {30'd0, bus_a_en, bus_b_en}, 32'd3);

        // R1 format codes, R7 saturation flags
        cfg_code = 2'd0; send(16'h1234, 16'hFEDC, 0, 0, "R1 offs");
        cfg_code = 2'd1; send(16'h7FFF, 16'h8000, 0, 0, "R7 sat twos");
        cfg_code = 2'd2; send(16'h0000, 16'h0001, 0, 0, "R1 gray");
        check("R1 gray of zero", {16'd0, bus_a}, 32'h0000C000);
        cfg_code = 2'd3; send(16'h8001, 16'h7FFE, 0, 0, "R1 offs alt");
        // R2 inversion
        cfg_invert = 1'b1; cfg_code = 2'd2; send(16'hA5A5, 16'h0F0F, 0, 0, "R2 invert gray");
        cfg_code = 2'd1; send(16'h0000, 16'hFFFF, 0, 0, "R2 invert twos");
        cfg_invert = 1'b0;
        // R4 hold between strobes
        check("R4 hold", {16'd0, bus_b}, {16'd0, fmt(16'hFFFF) ^ 16'hFFFF});
        // R8 threshold boundary, both signs
        cfg_ovr_mode = 2'd1; cfg_ovr_limit = 6'd8;
        send(16'h1200, 16'hEDFF, 0, 0, "R8 above limit");
        cfg_ovr_limit = 6'd9;
        send(16'h1200, 16'hEDFF, 0, 0, "R8 at limit");
        // R9 analog or saturation, and off mode
        cfg_ovr_mode = 2'd2; send(16'h0100, 16'h8000, 1, 0, "R9 analog or sat");
        cfg_ovr_mode = 2'd3; send(16'h7FFF, 16'h8000, 1, 1, "R9 off");
        cfg_ovr_mode = 2'd0;
        // R6 clock polarity
        cfg_clk_inv = 1'b1;
        @(negedge clk);
        check("R6 idle level", {31'd0, dclk_out}, 32'd1);
        send(16'h2222, 16'h3333, 0, 0, "R6 inverted clock");
        cfg_clk_inv = 1'b0;
        // R5 interleave and R3 bus B release
        cfg_merge = 1'b1;
        @(negedge clk);
        check("R3 merge releases B", {30'd0, bus_a_en, bus_b_en}, 32'd2);
        send(16'h4444, 16'h5555, 0, 0, "R5 interleave");
        // R5 back-to-back strobes: B word of first strobe is dropped
        sb_q.push_back(mk(16'h0101, 16'h0202, 0, 0, 1'b0, "R5 first A"));
        sb_q.push_back(mk(16'h0303, 16'h0404, 0, 0, 1'b0, "R5 second A"));
        sb_q.push_back(mk(16'h0303, 16'h0404, 0, 0, 1'b1, "R5 second B"));
        @(negedge clk);
        in_a = 16'h0101; in_b = 16'h0202; in_valid = 1'b1;
        @(negedge clk);
        in_a = 16'h0303; in_b = 16'h0404;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        cfg_merge = 1'b0;
        // R3 release
        cfg_hiz = 1'b1;
        @(negedge clk);
        check("R3 hiz", {30'd0, bus_a_en, bus_b_en}, 32'd0);
        cfg_hiz = 1'b0;
        check("R4 queue drained", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule